// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one node of a two-dimensional mesh on-chip network that holds no flits. Each cycle up to four flits arrive on the compass links and one new flit may be offered by the attached tile. Every arriving flit leaves on some output two clock edges later. The oldest flit has first claim on the output it wants. A flit whose wanted output is already taken is pushed onto a free link, even one that leads away from its destination. There is no stall path and no storage, so the node never applies backpressure to its neighbours.

The pipeline has two registered stages. The first stage computes each flit's dimension-ordered direction and sorts the flits by age. The second stage walks the sorted list and grants outputs, and the crossbar loads the granted flits into the output registers. The node's own coordinates are inputs, so one netlist can be placed at every tile. The tile's flit gets an output only after all through-traffic has been served. It is dropped from the node if no link is left, and the `inj_taken` flag tells the tile whether to offer it again.

Top module: `defl_router`

## Requirements
- R1: Every valid flit on a network input appears on exactly one output two clock edges after it is sampled. The count of valid outputs equals the count of valid network inputs plus `inj_taken`.
- R2: Output indices are North=0, East=1, South=2, West=3 and eject=4. The wanted output is East when the destination X is greater than the node X and West when it is less. With X equal, it is North when the destination Y is greater and South when it is less. A flit whose X and Y both equal the node's goes to eject.
- R3: Flits are served in order of decreasing age. Ties go to the lower input index, with North=0, East=1, South=2, West=3 and the tile flit last. Invalid inputs come after all valid ones.
- R4: In service order, a flit receives its wanted output whenever no earlier flit has taken that output.
- R5: A flit whose wanted output is taken is sent on the lowest-index free link among North, East, South and West.
- R6: At most one flit is ejected per cycle. When several have arrived, the oldest one (per R3) is ejected and the others are deflected per R5.
- R7: The tile flit enters with age 0 and is served after all through flits. `inj_taken` is high, alongside its output, exactly when it got an output. Otherwise it leaves no trace on any output.
- R8: The age on every outgoing flit is its incoming age plus one, held at the all-ones maximum.
- R9: After reset, all `out_valid` bits and `inj_taken` are low.
- R10: Destination coordinates and payload pass through to the granted output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | XW | X coordinate of this node |
| my_y | input | YW | Y coordinate of this node |
| in_valid | input | 4 | Valid per network input, index N,E,S,W |
| in_x | input | 4*XW | Destination X per network input |
| in_y | input | 4*YW | Destination Y per network input |
| in_age | input | 4*AW | Age per network input |
| in_data | input | 4*DW | Payload per network input |
| inj_valid | input | 1 | Tile offers a new flit |
| inj_x | input | XW | Destination X of tile flit |
| inj_y | input | YW | Destination Y of tile flit |
| inj_data | input | DW | Payload of tile flit |
| out_valid | output | 5 | Valid per output, N,E,S,W,eject |
| out_x | output | 5*XW | Destination X per output |
| out_y | output | 5*YW | Destination Y per output |
| out_age | output | 5*AW | Updated age per output |
| out_data | output | 5*DW | Payload per output |
| inj_taken | output | 1 | Tile flit was granted an output this cycle |

## Verification
The bench targets four cases: all four inputs already at this node, all four wanting one link, equal ages, and a full set of through flits alongside a tile flit. If the eject limit were wrong, two ejections would appear or a flit would vanish. If the tie-break were wrong, the flits of equal age would land on swapped ports. A node that let the tile flit in ahead of through traffic would fail to place a through flit. Ages of 14 and 15 are sent to catch an increment that wraps to zero, and the single-flit tests on every side of the node catch a swapped axis or sign in route computation.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NLINK = 4;
  localparam int NSLOT = NLINK + 1;
  localparam int PW    = 3;
  typedef enum logic [PW-1:0] {
    P_N = 3'd0, P_E = 3'd1, P_S = 3'd2, P_W = 3'd3, P_L = 3'd4
  } port_e;
endpackage

// File: rtl/defl_route.sv
module defl_route
  import defl_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output port_e         dir
);
  always_comb begin
    if (dst_x > my_x)      dir = P_E;
    else if (dst_x < my_x) dir = P_W;
    else if (dst_y > my_y) dir = P_N;
    else if (dst_y < my_y) dir = P_S;
    else                   dir = P_L;
  end
endmodule

// File: rtl/defl_rank.sv
module defl_rank
  import defl_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic          v_i    [NSLOT],
  input  logic [XW-1:0] x_i    [NSLOT],
  input  logic [YW-1:0] y_i    [NSLOT],
  input  logic [AW-1:0] age_i  [NSLOT],
  input  logic [DW-1:0] data_i [NSLOT],
  output logic          s_v    [NSLOT],
  output port_e         s_dir  [NSLOT],
  output logic [XW-1:0] s_x    [NSLOT],
  output logic [YW-1:0] s_y    [NSLOT],
  output logic [AW-1:0] s_age  [NSLOT],
  output logic [DW-1:0] s_data [NSLOT],
  output logic          s_loc  [NSLOT]
);
  port_e         dir  [NSLOT];
  logic [PW-1:0] pos  [NSLOT];
  logic          sel  [NSLOT][NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_rc
    defl_route #(.XW(XW), .YW(YW)) route_i (
      .my_x(my_x), .my_y(my_y), .dst_x(x_i[g]), .dst_y(y_i[g]), .dir(dir[g])
    );
  end

  function automatic logic beats(input logic vj, input logic vi,
                                 input logic [AW-1:0] aj, input logic [AW-1:0] ai,
                                 input int j, input int i);
    if (vj != vi) return vj;
    if (aj != ai) return aj > ai;
    return j < i;
  endfunction

  // position of each slot in the age order: number of slots ahead of it
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      pos[i] = '0;
      for (int j = 0; j < NSLOT; j++)
        if (j != i && beats(v_i[j], v_i[i], age_i[j], age_i[i], j, i))
          pos[i] = pos[i] + 1'b1;
      for (int r = 0; r < NSLOT; r++)
        sel[r][i] = (pos[i] == PW'(r));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NSLOT; r++) begin
        s_v[r] <= 1'b0; s_dir[r] <= P_N; s_x[r] <= '0; s_y[r] <= '0;
        s_age[r] <= '0; s_data[r] <= '0; s_loc[r] <= 1'b0;
      end
    end else begin
      for (int r = 0; r < NSLOT; r++)
        for (int i = 0; i < NSLOT; i++)
          if (sel[r][i]) begin
            s_v[r]    <= v_i[i];
            s_dir[r]  <= dir[i];
            s_x[r]    <= x_i[i];
            s_y[r]    <= y_i[i];
            s_age[r]  <= age_i[i];
            s_data[r] <= data_i[i];
            s_loc[r]  <= (i == NLINK);
          end
    end
  end

  // R3: the sorted list never has a valid entry behind an invalid one
  sorted_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_v[1] || s_v[0]) && (!s_v[2] || s_v[1]) && (!s_v[3] || s_v[2]) && (!s_v[4] || s_v[3]));
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc
  import defl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  s_v    [NSLOT],
  input  port_e s_dir  [NSLOT],
  output logic  g_ok   [NSLOT],
  output port_e g_port [NSLOT]
);
  logic [NSLOT-1:0] busy;

  always_comb begin
    busy = '0;
    for (int r = 0; r < NSLOT; r++) begin
      g_ok[r]   = 1'b0;
      g_port[r] = P_N;
      if (s_v[r]) begin
        if (!busy[s_dir[r]]) begin
          g_ok[r]   = 1'b1;
          g_port[r] = s_dir[r];
        end else begin
          for (int l = NLINK - 1; l >= 0; l--)
            if (!busy[l]) begin
              g_ok[r]   = 1'b1;
              g_port[r] = port_e'(PW'(l));
            end
        end
        if (g_ok[r]) busy[g_port[r]] = 1'b1;
      end
    end
  end

  // R4
  oldest_gets_wanted_chk: assert property (@(posedge clk) disable iff (rst)
    s_v[0] |-> (g_ok[0] && g_port[0] == s_dir[0]));
  // R5
  second_never_lost_chk: assert property (@(posedge clk) disable iff (rst)
    s_v[1] |-> (g_ok[1] && g_port[1] != g_port[0]));
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [XW-1:0]       my_x,
  input  logic [YW-1:0]       my_y,
  input  logic [NLINK-1:0]    in_valid,
  input  logic [NLINK*XW-1:0] in_x,
  input  logic [NLINK*YW-1:0] in_y,
  input  logic [NLINK*AW-1:0] in_age,
  input  logic [NLINK*DW-1:0] in_data,
  input  logic                inj_valid,
  input  logic [XW-1:0]       inj_x,
  input  logic [YW-1:0]       inj_y,
  input  logic [DW-1:0]       inj_data,
  output logic [NSLOT-1:0]    out_valid,
  output logic [NSLOT*XW-1:0] out_x,
  output logic [NSLOT*YW-1:0] out_y,
  output logic [NSLOT*AW-1:0] out_age,
  output logic [NSLOT*DW-1:0] out_data,
  output logic                inj_taken
);
  localparam logic [AW-1:0] AGE_MAX = {AW{1'b1}};

  logic          v_i [NSLOT];
  logic [XW-1:0] x_i [NSLOT];
  logic [YW-1:0] y_i [NSLOT];
  logic [AW-1:0] a_i [NSLOT];
  logic [DW-1:0] d_i [NSLOT];

  logic          s_v [NSLOT];
  port_e         s_dir [NSLOT];
  logic [XW-1:0] s_x [NSLOT];
  logic [YW-1:0] s_y [NSLOT];
  logic [AW-1:0] s_age [NSLOT];
  logic [DW-1:0] s_data [NSLOT];
  logic          s_loc [NSLOT];
  logic          g_ok [NSLOT];
  port_e         g_port [NSLOT];

  logic [XW-1:0] o_x [NSLOT];
  logic [YW-1:0] o_y [NSLOT];
  logic [AW-1:0] o_a [NSLOT];
  logic [DW-1:0] o_d [NSLOT];

  for (genvar g = 0; g < NLINK; g++) begin : g_in
    assign v_i[g] = in_valid[g];
    assign x_i[g] = in_x[g*XW +: XW];
    assign y_i[g] = in_y[g*YW +: YW];
    assign a_i[g] = in_age[g*AW +: AW];
    assign d_i[g] = in_data[g*DW +: DW];
  end
  assign v_i[NLINK] = inj_valid;
  assign x_i[NLINK] = inj_x;
  assign y_i[NLINK] = inj_y;
  assign a_i[NLINK] = '0;
  assign d_i[NLINK] = inj_data;

  defl_rank #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) rank_i (
    .clk(clk), .rst(rst), .my_x(my_x), .my_y(my_y),
    .v_i(v_i), .x_i(x_i), .y_i(y_i), .age_i(a_i), .data_i(d_i),
    .s_v(s_v), .s_dir(s_dir), .s_x(s_x), .s_y(s_y), .s_age(s_age),
    .s_data(s_data), .s_loc(s_loc)
  );

  defl_alloc alloc_i (
    .clk(clk), .rst(rst), .s_v(s_v), .s_dir(s_dir), .g_ok(g_ok), .g_port(g_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      inj_taken <= 1'b0;
      for (int p = 0; p < NSLOT; p++) begin
        o_x[p] <= '0; o_y[p] <= '0; o_a[p] <= '0; o_d[p] <= '0;
      end
    end else begin
      out_valid <= '0;
      inj_taken <= 1'b0;
      for (int r = 0; r < NSLOT; r++)
        if (g_ok[r]) begin
          out_valid[g_port[r]] <= 1'b1;
          o_x[g_port[r]] <= s_x[r];
          o_y[g_port[r]] <= s_y[r];
          o_a[g_port[r]] <= (s_age[r] == AGE_MAX) ? s_age[r] : s_age[r] + 1'b1;
          o_d[g_port[r]] <= s_data[r];
          if (s_loc[r]) inj_taken <= 1'b1;
        end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_out
    assign out_x[g*XW +: XW]    = o_x[g];
    assign out_y[g*YW +: YW]    = o_y[g];
    assign out_age[g*AW +: AW]  = o_a[g];
    assign out_data[g*DW +: DW] = o_d[g];
  end

  // checker-side views of the stage boundary
  int               thru_cnt;
  logic             loc_present;
  logic [NSLOT-1:0] age_zero;
  always_comb begin
    thru_cnt    = 0;
    loc_present = 1'b0;
    for (int r = 0; r < NSLOT; r++) begin
      if (s_v[r] && !s_loc[r]) thru_cnt++;
      if (s_v[r] && s_loc[r]) loc_present = 1'b1;
      age_zero[r] = (o_a[r] == '0);
    end
  end

  // R1
  flit_conserved_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) == $past(thru_cnt) + int'(inj_taken));
  // R6
  eject_at_home_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[P_L] |-> (o_x[P_L] == $past(my_x) && o_y[P_L] == $past(my_y)));
  // R7
  inject_had_flit_chk: assert property (@(posedge clk) disable iff (rst)
    inj_taken |-> $past(loc_present));
  // R8
  age_advanced_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid & age_zero) == '0);
  // R9
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && !inj_taken));
endmodule

// File: tb/defl_router_tb_top.sv
`timescale 1ns/1ps
module defl_router_tb_top;
  localparam int XW = 3, YW = 3, AW = 4, DW = 8;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [XW-1:0] my_x = '0;
  logic [YW-1:0] my_y = '0;
  logic [3:0] in_valid = '0;
  logic [4*XW-1:0] in_x = '0;
  logic [4*YW-1:0] in_y = '0;
  logic [4*AW-1:0] in_age = '0;
  logic [4*DW-1:0] in_data = '0;
  logic inj_valid = 1'b0;
  logic [XW-1:0] inj_x = '0;
  logic [YW-1:0] inj_y = '0;
  logic [DW-1:0] inj_data = '0;
  logic [NS-1:0] out_valid;
  logic [NS*XW-1:0] out_x;
  logic [NS*YW-1:0] out_y;
  logic [NS*AW-1:0] out_age;
  logic [NS*DW-1:0] out_data;
  logic inj_taken;

  always #2.5 clk = ~clk;

  defl_router #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [NS-1:0] e_v [4];
  logic [XW-1:0] e_x [4][NS];
  logic [YW-1:0] e_y [4][NS];
  logic [AW-1:0] e_a [4][NS];
  logic [DW-1:0] e_d [4][NS];
  logic          e_inj [4];
  int            e_thru [4];
  string         e_tag [4];

  task automatic chk(string req, string tag, int p, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) port %0d act=%0h exp=%0h", req, tag, p, act, exp);
    end
  endtask

  function automatic int want(int dx, int dy);
    if (dx > int'(my_x)) return 1;
    if (dx < int'(my_x)) return 3;
    if (dy > int'(my_y)) return 0;
    if (dy < int'(my_y)) return 2;
    return 4;
  endfunction

  // expected outputs from the requirements for the inputs currently driven
  task automatic model(int s, string tag);
    logic vv [NS]; int xx [NS]; int yy [NS]; int aa [NS]; int dd [NS];
    bit used [NS]; bit busy [NS];
    for (int i = 0; i < NS; i++) begin
      used[i] = 0; busy[i] = 0;
      if (i < 4) begin
        vv[i] = in_valid[i]; xx[i] = in_x[i*XW +: XW]; yy[i] = in_y[i*YW +: YW];
        aa[i] = in_age[i*AW +: AW]; dd[i] = in_data[i*DW +: DW];
      end else begin
        vv[i] = inj_valid; xx[i] = inj_x; yy[i] = inj_y; aa[i] = 0; dd[i] = inj_data;
      end
    end
    e_v[s] = '0; e_inj[s] = 0; e_tag[s] = tag; e_thru[s] = 0;
    for (int i = 0; i < 4; i++) if (vv[i]) e_thru[s]++;
    for (int k = 0; k < NS; k++) begin
      int b = -1;
      for (int i = 0; i < NS; i++)
        if (!used[i]) begin
          if (b < 0) b = i;
          else if ((vv[i] && !vv[b]) || (vv[i] == vv[b] && aa[i] > aa[b])) b = i;
        end
      used[b] = 1;
      if (vv[b]) begin
        int w = want(xx[b], yy[b]);
        int got = -1;
        if (!busy[w]) got = w;
        else for (int l = 0; l < 4; l++) if (!busy[l] && got < 0) got = l;
        if (got >= 0) begin
          busy[got] = 1;
          e_v[s][got] = 1'b1;
          e_x[s][got] = XW'(xx[b]); e_y[s][got] = YW'(yy[b]);
          e_a[s][got] = (aa[b] == (1 << AW) - 1) ? AW'(aa[b]) : AW'(aa[b] + 1);
          e_d[s][got] = DW'(dd[b]);
          if (b == 4) e_inj[s] = 1;
        end
      end
    end
  endtask

  task automatic check_slot(int s);
    for (int p = 0; p < NS; p++) begin
      chk(p == 4 ? "R6" : "R4 R5", e_tag[s], p, 32'(out_valid[p]), 32'(e_v[s][p]));
      if (e_v[s][p]) begin
        chk("R10", e_tag[s], p, {out_x[p*XW +: XW], out_y[p*YW +: YW], out_data[p*DW +: DW]},
            {e_x[s][p], e_y[s][p], e_d[s][p]});
        chk("R8", e_tag[s], p, 32'(out_age[p*AW +: AW]), 32'(e_a[s][p]));
      end
    end
    chk("R7", e_tag[s], 5, 32'(inj_taken), 32'(e_inj[s]));
    chk("R1", e_tag[s], 9, $countones(out_valid) - int'(inj_taken), e_thru[s]);
  endtask

  task automatic step(string tag);
    model(cyc % 4, tag);
    @(negedge clk);
    cyc++;
    if (cyc >= 2) check_slot((cyc - 2) % 4);
  endtask

  task automatic put(int p, int dx, int dy, int age, int data);
    in_valid[p] = 1'b1;
    in_x[p*XW +: XW] = XW'(dx); in_y[p*YW +: YW] = YW'(dy);
    in_age[p*AW +: AW] = AW'(age); in_data[p*DW +: DW] = DW'(data);
  endtask

  task automatic clear();
    in_valid = '0; inj_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9", "reset", 0, 32'(out_valid), 0);
    chk("R9", "reset", 1, 32'(inj_taken), 0);
    rst = 1'b0;
    my_x = 3'd3; my_y = 3'd3;
    // R2: one flit toward each side and one at home
    clear(); put(0, 5, 3, 1, 8'h11); step("R2 east");
    clear(); put(0, 1, 3, 1, 8'h12); step("R2 west");
    clear(); put(0, 3, 6, 1, 8'h13); step("R2 north");
    clear(); put(0, 3, 0, 1, 8'h14); step("R2 south");
    clear(); put(2, 3, 3, 1, 8'h15); step("R2 eject");
    // R3 R6: all at home, ties between E and S
    clear(); put(0, 3, 3, 2, 8'h21); put(1, 3, 3, 7, 8'h22);
    put(2, 3, 3, 7, 8'h23); put(3, 3, 3, 1, 8'h24); step("R3 R6 all home");
    // R4 R5: all want East
    clear(); put(0, 7, 1, 3, 8'h31); put(1, 6, 2, 9, 8'h32);
    put(2, 5, 5, 4, 8'h33); put(3, 4, 0, 3, 8'h34); step("R4 R5 same want");
    // R7: full through traffic blocks tile flit, then three let it in
    clear(); put(0, 0, 0, 1, 1); put(1, 1, 1, 1, 2); put(2, 2, 2, 1, 3); put(3, 4, 4, 1, 4);
    inj_valid = 1'b1; inj_x = 3'd6; inj_y = 3'd6; inj_data = 8'h55; step("R7 blocked");
    in_valid[3] = 1'b0; step("R7 admitted");
    // R8: saturation and increment near the top
    clear(); put(1, 0, 3, 15, 8'h81); put(3, 7, 3, 14, 8'h82); step("R8 saturate");
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) begin my_x = XW'($urandom); my_y = YW'($urandom); end
      for (int p = 0; p < 4; p++) begin
        in_valid[p] = ($urandom % 4) != 0;
        in_x[p*XW +: XW] = XW'($urandom); in_y[p*YW +: YW] = YW'($urandom);
        in_age[p*AW +: AW] = ($urandom % 3 == 0) ? AW'($urandom % 3) : AW'($urandom);
        in_data[p*DW +: DW] = DW'($urandom);
      end
      inj_valid = $urandom % 2; inj_x = XW'($urandom); inj_y = YW'($urandom);
      inj_data = DW'($urandom);
      step("rand");
    end
    clear(); step("flush"); step("flush");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule